// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock into a one-cycle sampling enable at sixteen times the serial bit rate. The UART transmitter uses the enable to shift bits and the receiver uses it to sample. The divisor has a 16-bit integer part, made of a low byte and a high byte, and a 4-bit fraction in sixteenths. The fraction is realised by dithering: each output period lasts either the integer divisor or one cycle more, as chosen by the carry of a small accumulator. Averaged over sixteen periods, the rate is exact.

A select input puts a divide-by-4 stage in front of the divider. The stage is a clock enable and not a derived clock, so the whole block runs on the one reference clock. Each UART channel instantiates its own copy. Software changes the rate by writing the divisor bytes and the fraction through three write strobes that share a data bus. Every such write restarts the generator cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the low divisor byte holds 0x01, the high byte 0x00 and the fraction 0. With `pre_sel` low, `tick` is high on every clock cycle from the first cycle after reset.
- R2: On a rising clock edge, `wr_lo` loads `wdata` into the low divisor byte, `wr_hi` loads `wdata` into the high byte, and `wr_frac` loads `wdata[3:0]` into the fraction. The integer divisor is {high, low}, and a register that is not written keeps its value.
- R3: The accumulator starts at 0 and adds the fraction once per output period, modulo 16. A period lasts the integer divisor when that addition does not reach 16, and the integer divisor plus one when it does. Sixteen periods therefore span 16×int + frac counted cycles.
- R4: An integer divisor of 0 behaves as 1, whatever the fraction.
- R5: With `pre_sel` high, the divider counts only on every fourth clock cycle, so every period lasts four times as many clock cycles.
- R6: A write strobe on any of the three registers clears the divider count, the accumulator and the prescaler phase at that clock edge. The k-th tick after the write then falls m×S(k)−1 cycles after the edge. Here the first cycle after the edge is cycle 0, m is 4 with `pre_sel` high and 1 otherwise, and S(k) is the sum of the first k period lengths from R3.
- R7: `tick` lasts exactly one clock cycle. With `pre_sel` high, two ticks are never on consecutive cycles.
- R8: The divider count always stays below the length of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the divisor low byte |
| wr_hi | input | 1 | Write strobe for the divisor high byte |
| wr_frac | input | 1 | Write strobe for the fraction, bits 3:0 of `wdata` |
| wdata | input | 8 | Write data shared by the three strobes |
| pre_sel | input | 1 | High selects the divide-by-4 prescaler |
| tick | output | 1 | Sampling enable at sixteen times the bit rate |

## Verification
The main sweep covers every fraction from 0 to 15 against integer divisors of 0, 1, 2, 3 and 5, both with and without the prescaler. Each run lasts seventeen periods, enough for the accumulator to wrap. The all-fractions sweep separates a correct carry pattern from one that is off by one period or lengthens the wrong period. The zero divisor shows the clamp, and the prescaled half shows that enable gating multiplies every period and not only the first. A larger divisor written first in full and then through the low byte alone shows that the bytes combine correctly and that an unwritten byte is retained. The reset run shows the fastest-rate default.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int BYTE_W = 8;
  localparam int INT_W  = 2 * BYTE_W;
  localparam int FRAC_W = 4;
  localparam logic [BYTE_W-1:0] LO_RESET = 8'h01;
  localparam logic [BYTE_W-1:0] HI_RESET = 8'h00;

  typedef struct packed {
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac;
  } fbg_div_t;

  // Integer divisor with zero promoted to one.
  function automatic logic [INT_W-1:0] fbg_clamp(input logic [INT_W-1:0] raw);
    return (raw == '0) ? {{(INT_W-1){1'b0}}, 1'b1} : raw;
  endfunction

  // One accumulator step: {carry, new accumulator}.
  function automatic logic [FRAC_W:0] fbg_step(input logic [FRAC_W-1:0] acc,
                                               input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

  // Period length in counted cycles.
  function automatic logic [INT_W:0] fbg_len(input logic [INT_W-1:0] eff,
                                             input logic carry);
    return {1'b0, eff} + {{INT_W{1'b0}}, carry};
  endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_frac,
  input  logic [BYTE_W-1:0] wdata,
  output fbg_div_t          div,
  output logic              restart
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [FRAC_W-1:0] frac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= LO_RESET;
      hi_q   <= HI_RESET;
      frac_q <= '0;
    end else begin
      if (wr_lo)   lo_q   <= wdata;
      if (wr_hi)   hi_q   <= wdata;
      if (wr_frac) frac_q <= wdata[FRAC_W-1:0];
    end
  end

  assign div.int_part = {hi_q, lo_q};
  assign div.frac     = frac_q;
  assign restart      = wr_lo | wr_hi | wr_frac;
endmodule

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pre_sel,
  output logic pre_en
);
  generate
    if (RATIO > 1) begin : g_div
      localparam int PW = $clog2(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase_q <= '0;
        else if (restart)          phase_q <= '0;
        else if (phase_q == LAST)  phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
      end
      assign pre_en = pre_sel ? (phase_q == LAST) : 1'b1;
    end else begin : g_pass
      assign pre_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/fbg_core.sv
module fbg_core
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_en,
  input  fbg_div_t          div,
  output logic              tick,
  output logic [INT_W:0]    cnt,
  output logic [FRAC_W-1:0] acc,
  output logic [INT_W:0]    len,
  output logic [INT_W-1:0]  eff_int
);
  localparam logic [INT_W:0] ONE = {{INT_W{1'b0}}, 1'b1};

  logic [INT_W:0]    cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   step;
  logic              period_end;

  assign eff_int    = fbg_clamp(div.int_part);
  assign step       = fbg_step(acc_q, div.frac);
  assign len        = fbg_len(eff_int, step[FRAC_W]);
  assign period_end = (cnt_q + ONE) == len;
  assign tick       = pre_en & period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (pre_en) begin
      if (period_end) begin
        cnt_q <= '0;
        acc_q <= step[FRAC_W-1:0];
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign cnt = cnt_q;
  assign acc = acc_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int PRE_RATIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_frac,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pre_sel,
  output logic              tick
);
  fbg_div_t          div;
  logic              restart;
  logic              pre_en;
  logic [INT_W:0]    cnt;
  logic [FRAC_W-1:0] acc;
  logic [INT_W:0]    len;
  logic [INT_W-1:0]  eff_int;

  fbg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_frac(wr_frac), .wdata(wdata), .div(div), .restart(restart)
  );

  fbg_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pre_sel(pre_sel),
    .pre_en(pre_en)
  );

  fbg_core u_core (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pre_en(pre_en),
    .div(div), .tick(tick), .cnt(cnt), .acc(acc), .len(len),
    .eff_int(eff_int)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
  import fbg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pre_sel,
  input logic              tick,
  input logic              restart,
  input logic              pre_en,
  input logic [INT_W:0]    cnt,
  input logic [FRAC_W-1:0] acc,
  input logic [INT_W:0]    len,
  input logic [INT_W-1:0]  eff_int,
  input fbg_div_t          div
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len); // R8

  AST_NONZERO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    eff_int != '0); // R4

  AST_TICK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pre_en); // R7

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_sel && !restart) |=> (!tick || !pre_sel)); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && acc == '0)); // R6

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(acc)); // R3

  AST_FASTEST: assert property (@(posedge clk) disable iff (!rst_n)
    (div.int_part == 16'd1 && div.frac == '0 && !pre_sel) |-> tick); // R1
endmodule

bind frac_baud_gen fbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .tick(tick),
  .restart(restart), .pre_en(pre_en), .cnt(cnt), .acc(acc), .len(len),
  .eff_int(eff_int), .div(div)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, wr_frac = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       pre_sel = 1'b0;
  logic       tick;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_frac(wr_frac), .wdata(wdata), .pre_sel(pre_sel), .tick(tick)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One-cycle write strobe, applied at a falling edge.
  task automatic put(input bit lo, input bit hi, input bit fr, input logic [7:0] d);
    @(negedge clk);
    wr_lo = lo; wr_hi = hi; wr_frac = fr; wdata = d;
    @(posedge clk);
    #1;
    wr_lo = 1'b0; wr_hi = 1'b0; wr_frac = 1'b0;
  endtask

  // Tick positions after the last write, from R3, R4, R5 and R6.
  task automatic measure(input int raw_int, input int frac, input bit pre, input int nper, input string req);
    int m = pre ? 4 : 1;
    int ei = (raw_int == 0) ? 1 : raw_int;
    int acc = 0;
    int s = 0;
    int next_exp;
    int sum = acc + frac;
    int k = 1;
    int last;
    s = ei + ((sum >= 16) ? 1 : 0);
    acc = sum % 16;
    next_exp = m * s - 1;
    last = next_exp;
    for (int idx = 0; idx <= last; idx++) begin
      @(negedge clk);
      if (idx == next_exp) begin
        check(tick === 1'b1, req, int'(tick), 1, $sformatf("tick %0d at cycle %0d int=%0d frac=%0d pre=%0d", k, idx, raw_int, frac, pre));
        if (k < nper) begin
          k++;
          sum = acc + frac;
          s += ei + ((sum >= 16) ? 1 : 0);
          acc = sum % 16;
          next_exp = m * s - 1;
          last = next_exp;
        end
      end else begin
        check(tick === 1'b0, req, int'(tick), 0, $sformatf("idle at cycle %0d int=%0d frac=%0d pre=%0d", idx, raw_int, frac, pre));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset defaults give a tick on every cycle.
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(tick === 1'b1, "R1", int'(tick), 1, "reset default tick");
    end

    // R3 R4 R5 R6 R7: sweep all fractions over small divisors, both prescale modes.
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 5; d++) begin
        int iv = (d == 4) ? 5 : d;
        for (int f = 0; f < 16; f++) begin
          pre_sel = p[0];
          put(1'b0, 1'b1, 1'b0, 8'h00);
          put(1'b1, 1'b0, 1'b0, 8'(iv));
          put(1'b0, 1'b0, 1'b1, 8'(f));
          measure(iv, f, p[0], 17, (iv == 0) ? "R4" : (p != 0 ? "R5" : "R3"));
        end
      end
    end

    // R2: both bytes combine into {hi, lo}.
    pre_sel = 1'b0;
    put(1'b1, 1'b1, 1'b1, 8'h01);   // lo=1 hi=1 frac=1 in one cycle
    put(1'b1, 1'b0, 1'b0, 8'h02);   // lo=2
    measure(258, 1, 1'b0, 3, "R2");
    // R2: writing only the low byte keeps the high byte.
    put(1'b1, 1'b0, 1'b0, 8'h04);
    measure(260, 1, 1'b0, 2, "R2");
    // R6: mid-period rewrite of the same value restarts the count.
    put(1'b1, 1'b1, 1'b1, 8'h00);
    put(1'b1, 1'b0, 1'b0, 8'h07);
    repeat (4) @(negedge clk);
    put(1'b1, 1'b0, 1'b0, 8'h07);
    measure(7, 0, 1'b0, 3, "R6");
    // R5 R7: prescaled larger divisor.
    pre_sel = 1'b1;
    put(1'b0, 1'b0, 1'b1, 8'h0f);
    measure(7, 15, 1'b1, 4, "R7");
    report();
  end
endmodule